// File: doc/BRIEF.md
# Nested Region Memo Recorder

This block sits beside a processor core and records the input and output values of reusable instruction regions while those regions run. A region is either a function body, running from entry at the callee to its return, or one loop iteration, running from a backward branch to the branch target. The core reports each region begin and region end as an event. It reports each data read or write with its address and value. It also supplies two stack-pointer values: the live stack pointer and the stack pointer held just before the current call.

The recorder keeps one linear record line per nesting level, and six levels can be open at once. A read is an input of a region and a write is one of its outputs. Every access goes at once into the line of every open level, so each enclosing region also collects what its inner regions touched. Addresses that belong to the current function's own frame are filtered out and never recorded.

When a region closes, its finished line is streamed out one entry per beat with a valid/ready handshake, and a closing marker beat follows. The line then drops from the nesting stack. While a line is streaming, the event inputs are refused.

Top module: `mrec_top`

## Requirements
- R1: After reset the nesting depth is zero, `fl_valid` is low and `ev_ready` is high.
- R2: `rgn_begin` raises the depth by one, and `rgn_end` closes the innermost open region. An `rgn_end` with no open region has no effect. A level that is not open holds an empty line.
- R3: Each recorded access becomes one entry holding `write` (1 = write, 0 = read), address and value. At region end the innermost line streams its entries in the order they arrived. One more beat with `fl_eol`=1 follows, with address and data at zero. `fl_kind` carries the region kind given at begin (0 = function, 1 = loop) on every beat.
- R4: One access is appended to the line of every open level in the same cycle. `fl_level` gives the line's index, with 0 being the outermost region.
- R5: An access whose address lies in the range [`sp_now`, `sp_frame`) is not recorded. Addresses below `sp_now`, and at or above `sp_frame`, are recorded.
- R6: A read whose address is already in a line, whether as a read or as a write, is not added to that line. Writes are always added.
- R7: A region opened while six levels are already open is not recorded, and its end produces no stream. Its accesses are still recorded into the six outer lines.
- R8: An access that finds its line holding `LINE_DEPTH` entries marks that line as overflowed. An overflowed line is dropped at its region end: no beat is streamed, and the depth still falls by one.
- R9: While `fl_valid` is high and `fl_ready` is low, every stream output holds its value. `ev_ready` is low from the first stream beat until the marker beat has been accepted.
- R10: Begin, end and access inputs are acted on only in cycles with `ev_ready` high, and at most one of them is raised in any such cycle. Inputs raised while `ev_ready` is low leave every line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rgn_begin | input | 1 | A region opens this cycle |
| rgn_kind | input | 1 | Kind of the opening region: 0 function, 1 loop |
| rgn_end | input | 1 | The innermost region closes this cycle |
| acc_valid | input | 1 | A data access is reported this cycle |
| acc_write | input | 1 | 1 write (output), 0 read (input) |
| acc_addr | input | 16 | Access address |
| acc_data | input | 16 | Access value |
| sp_now | input | 16 | Live stack pointer, lower bound of the local frame |
| sp_frame | input | 16 | Stack pointer before the call, upper bound (exclusive) of the local frame |
| ev_ready | output | 1 | Events are accepted this cycle |
| fl_valid | output | 1 | Stream beat valid |
| fl_ready | input | 1 | Receiver takes the beat |
| fl_eol | output | 1 | Beat is the end-of-line marker |
| fl_write | output | 1 | Entry is a write |
| fl_addr | output | 16 | Entry address |
| fl_data | output | 16 | Entry value |
| fl_level | output | 3 | Nesting level of the streamed line |
| fl_kind | output | 1 | Kind of the streamed region |

FSM states: `ST_IDLE` accepts events. `ST_STREAM` sends entries. `ST_MARK` sends the marker. The transitions are as follows:
- IDLE→STREAM on an end whose line is non-empty and not overflowed.
- IDLE→MARK on an end whose line is empty.
- STREAM→STREAM on each accepted entry that is not the last.
- STREAM→MARK on the accepted last entry.
- MARK→IDLE on the accepted marker.

## Verification
The hardest state to reach is a seventh nested region, which must stay unrecorded while all six outer lines each take the same access. The stimulus opens seven regions in a row and issues one read at the deepest level. It then closes them one by one, and expects no stream for the deepest region and a two-beat stream for each of the six others. Overflow is reached by writing one more distinct address than a line holds. A later short region then proves that the dropped line left the nesting depth correct. A behavioural model with per-level queues is compared with the outputs on every clock, while the receiver applies a repeating backpressure pattern.

// File: rtl/mrec_pkg.sv
package mrec_pkg;
    localparam int MR_AW = 16;
    localparam int MR_DW = 16;

    typedef struct packed {
        logic              wr;
        logic [MR_AW-1:0]  addr;
        logic [MR_DW-1:0]  data;
    } mr_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_MARK
    } mr_state_t;
endpackage

// File: rtl/mrec_filter.sv
module mrec_filter #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo_bound,
    input  logic [AW-1:0] hi_bound,
    output logic          in_frame
);
    always_comb begin
        in_frame = (addr >= lo_bound) && (addr < hi_bound);
    end
endmodule

// File: rtl/mrec_line.sv
module mrec_line
    import mrec_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               app_en,
    input  logic               acc_write,
    input  logic [MR_AW-1:0]   acc_addr,
    input  logic [MR_DW-1:0]   acc_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output mr_entry_t          rd_entry,
    output logic [CNT_W-1:0]   cnt,
    output logic               ovf
);
    mr_entry_t mem [DEPTH];
    logic      hit;
    logic      want;
    logic      wr_en;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CNT_W'(i) < cnt) && (mem[i].addr == acc_addr)) begin
                hit = 1'b1;
            end
        end
    end

    assign want  = app_en && !clr && (acc_write || !hit);
    assign wr_en = want && (cnt != CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (want) begin
            if (cnt == CNT_W'(DEPTH)) begin
                ovf <= 1'b1;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[IDX_W'(cnt)] <= '{wr: acc_write, addr: acc_addr, data: acc_data};
        end
    end

    assign rd_entry = mem[rd_idx];

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr |=> ovf); // R8
    AST_READ_DEDUP: assert property (@(posedge clk) disable iff (!rst_n)
        app_en && !clr && !acc_write && hit |=> $stable(cnt) && $stable(ovf)); // R6
    AST_WRITE_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        app_en && !clr && acc_write && (cnt != CNT_W'(DEPTH)) |=> cnt == $past(cnt) + CNT_W'(1)); // R6
endmodule

// File: rtl/mrec_top.sv
module mrec_top
    import mrec_pkg::*;
#(
    parameter int LEVELS     = 6,
    parameter int LINE_DEPTH = 8,
    parameter int MAX_NEST   = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rgn_begin,
    input  logic               rgn_kind,
    input  logic               rgn_end,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [MR_AW-1:0]   acc_addr,
    input  logic [MR_DW-1:0]   acc_data,
    input  logic [MR_AW-1:0]   sp_now,
    input  logic [MR_AW-1:0]   sp_frame,
    output logic               ev_ready,
    output logic               fl_valid,
    input  logic               fl_ready,
    output logic               fl_eol,
    output logic               fl_write,
    output logic [MR_AW-1:0]   fl_addr,
    output logic [MR_DW-1:0]   fl_data,
    output logic [$clog2(LEVELS)-1:0] fl_level,
    output logic               fl_kind
);
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int IDX_W  = $clog2(LINE_DEPTH);
    localparam int CNT_W  = $clog2(LINE_DEPTH + 1);
    localparam int NEST_W = $clog2(MAX_NEST + 1);

    mr_state_t         state, nxt;
    logic [NEST_W-1:0] nest;
    logic [LVL_W-1:0]  fl_lvl;
    logic [IDX_W-1:0]  rd_ptr;
    logic              kinds [LEVELS];

    logic              is_local;
    logic              idle;
    logic              acc_go, end_go, beg_go;
    logic              deep;
    logic [LVL_W-1:0]  top_lvl;
    logic              discard;
    logic              finish;

    logic [CNT_W-1:0]  line_cnt [LEVELS];
    logic              line_ovf [LEVELS];
    mr_entry_t         line_rd  [LEVELS];
    logic              line_clr [LEVELS];
    logic              line_app [LEVELS];

    mrec_filter #(.AW(MR_AW)) u_filter (
        .addr     (acc_addr),
        .lo_bound (sp_now),
        .hi_bound (sp_frame),
        .in_frame (is_local)
    );

    assign idle    = (state == ST_IDLE);
    assign beg_go  = idle && rgn_begin;
    assign end_go  = idle && rgn_end && !rgn_begin && (nest != '0);
    assign acc_go  = idle && acc_valid && !rgn_begin && !rgn_end && !is_local;
    assign deep    = nest > NEST_W'(LEVELS);
    assign top_lvl = LVL_W'(nest - NEST_W'(1));
    assign discard = end_go && !deep && line_ovf[top_lvl];
    assign finish  = (state == ST_MARK) && fl_ready;

    for (genvar g = 0; g < LEVELS; g++) begin : g_line
        assign line_app[g] = acc_go && (NEST_W'(g) < nest);
        assign line_clr[g] = (discard && (top_lvl == LVL_W'(g))) ||
                             (finish && (fl_lvl == LVL_W'(g)));

        mrec_line #(
            .DEPTH (LINE_DEPTH),
            .IDX_W (IDX_W),
            .CNT_W (CNT_W)
        ) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (line_clr[g]),
            .app_en    (line_app[g]),
            .acc_write (acc_write),
            .acc_addr  (acc_addr),
            .acc_data  (acc_data),
            .rd_idx    (rd_ptr),
            .rd_entry  (line_rd[g]),
            .cnt       (line_cnt[g]),
            .ovf       (line_ovf[g])
        );

        AST_INACTIVE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            (NEST_W'(g) >= nest) |-> (line_cnt[g] == '0) && !line_ovf[g]); // R2
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (end_go && !deep && !line_ovf[top_lvl]) begin
                    nxt = (line_cnt[top_lvl] == '0) ? ST_MARK : ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (fl_ready && (rd_ptr == IDX_W'(line_cnt[fl_lvl] - CNT_W'(1)))) begin
                    nxt = ST_MARK;
                end
            end
            ST_MARK: begin
                if (fl_ready) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // nesting and stream pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nest   <= '0;
            fl_lvl <= '0;
            rd_ptr <= '0;
            for (int i = 0; i < LEVELS; i++) begin
                kinds[i] <= 1'b0;
            end
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (beg_go) begin
                        if (nest != NEST_W'(MAX_NEST)) begin
                            nest <= nest + NEST_W'(1);
                            if (nest < NEST_W'(LEVELS)) begin
                                kinds[LVL_W'(nest)] <= rgn_kind;
                            end
                        end
                    end else if (end_go) begin
                        if (deep || discard) begin
                            nest <= nest - NEST_W'(1);
                        end else begin
                            fl_lvl <= top_lvl;
                            rd_ptr <= '0;
                        end
                    end
                end
                ST_STREAM: begin
                    if (fl_ready) begin
                        rd_ptr <= rd_ptr + IDX_W'(1);
                    end
                end
                ST_MARK: begin
                    if (fl_ready) begin
                        nest <= nest - NEST_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ev_ready = idle;
        fl_valid = !idle;
        fl_eol   = (state == ST_MARK);
        fl_level = fl_lvl;
        fl_kind  = kinds[fl_lvl];
        fl_write = 1'b0;
        fl_addr  = '0;
        fl_data  = '0;
        if (state == ST_STREAM) begin
            fl_write = line_rd[fl_lvl].wr;
            fl_addr  = line_rd[fl_lvl].addr;
            fl_data  = line_rd[fl_lvl].data;
        end
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ready |-> $onehot0({rgn_begin, rgn_end, acc_valid})); // R10
    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid && !fl_ready |=> fl_valid && $stable(fl_eol) && $stable(fl_write)
            && $stable(fl_addr) && $stable(fl_data) && $stable(fl_level)); // R9
    AST_EOL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid && fl_eol && fl_ready |=> ev_ready); // R3
    AST_DEEP_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ready && rgn_end && !rgn_begin && (nest > NEST_W'(LEVELS)) |=> ev_ready); // R7
endmodule

// File: tb/mrec_top_bench.sv
module mrec_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rgn_begin, rgn_kind, rgn_end;
    logic        acc_valid, acc_write;
    logic [15:0] acc_addr, acc_data, sp_now, sp_frame;
    logic        ev_ready, fl_valid, fl_ready, fl_eol, fl_write, fl_kind;
    logic [15:0] fl_addr, fl_data;
    logic [2:0]  fl_level;

    int total = 0;
    int bad   = 0;
    int beats = 0;
    int rp    = 0;

    // reference model
    logic [32:0] mq [6][$];
    logic        mo [6];
    logic        mk [6];
    int          md = 0;
    int          ms = 0;
    int          mfl = 0;
    int          mix = 0;

    always #5 clk = ~clk;

    mrec_top u_mrec_top (
        .clk(clk), .rst_n(rst_n), .rgn_begin(rgn_begin), .rgn_kind(rgn_kind),
        .rgn_end(rgn_end), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_data(acc_data), .sp_now(sp_now), .sp_frame(sp_frame),
        .ev_ready(ev_ready), .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_eol(fl_eol),
        .fl_write(fl_write), .fl_addr(fl_addr), .fl_data(fl_data),
        .fl_level(fl_level), .fl_kind(fl_kind)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_outputs();
        logic [32:0] e;
        chk(ev_ready == (ms == 0), "R9 ev_ready", int'(ev_ready), int'(ms == 0));
        chk(fl_valid == (ms != 0), "R9 fl_valid", int'(fl_valid), int'(ms != 0));
        chk(fl_eol == (ms == 2), "R3 fl_eol", int'(fl_eol), int'(ms == 2));
        if (ms == 1) begin
            e = mq[mfl][mix];
            chk({fl_write, fl_addr, fl_data} == e, "R3 entry", int'({fl_addr, fl_data}), int'(e[31:0]));
            chk(fl_write == e[32], "R3 write flag", int'(fl_write), int'(e[32]));
        end
        if (ms != 0) begin
            chk(int'(fl_level) == mfl, "R4 fl_level", int'(fl_level), mfl);
            chk(fl_kind == mk[mfl], "R3 fl_kind", int'(fl_kind), int'(mk[mfl]));
        end
        if (ms == 2) begin
            chk(fl_addr == 16'h0 && fl_data == 16'h0, "R3 marker fields", int'(fl_addr), 0);
        end
    endtask

    task automatic step(input logic b, input logic k, input logic e, input logic a,
                        input logic w, input logic [15:0] ad, input logic [15:0] dt);
        logic rdy;
        logic dup;
        @(negedge clk);
        compare_outputs();
        rdy = ((rp % 3) != 1);
        rp++;
        rgn_begin = b; rgn_kind = k; rgn_end = e;
        acc_valid = a; acc_write = w; acc_addr = ad; acc_data = dt;
        fl_ready  = rdy;
        if (fl_valid && rdy) beats++;
        if (ms == 0) begin
            if (b) begin
                if (md < 15) begin
                    md++;
                    if (md <= 6) begin
                        mq[md-1].delete();
                        mo[md-1] = 1'b0;
                        mk[md-1] = k;
                    end
                end
            end else if (e) begin
                if (md > 0) begin
                    if (md > 6) begin
                        md--;
                    end else if (mo[md-1]) begin
                        mq[md-1].delete();
                        mo[md-1] = 1'b0;
                        md--;
                    end else begin
                        mfl = md - 1;
                        mix = 0;
                        ms  = (mq[mfl].size() == 0) ? 2 : 1;
                    end
                end
            end else if (a && !(ad >= sp_now && ad < sp_frame)) begin
                for (int l = 0; l < 6; l++) begin
                    if (l < md) begin
                        dup = 1'b0;
                        foreach (mq[l][i]) if (mq[l][i][31:16] == ad) dup = 1'b1;
                        if (w || !dup) begin
                            if (mq[l].size() == 8) mo[l] = 1'b1;
                            else mq[l].push_back({w, ad, dt});
                        end
                    end
                end
            end
        end else if (ms == 1) begin
            if (rdy) begin
                if (mix == mq[mfl].size() - 1) ms = 2;
                else mix++;
            end
        end else if (rdy) begin
            mq[mfl].delete();
            md--;
            ms = 0;
        end
    endtask

    task automatic t_begin(input logic k);
        step(1'b1, k, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
    endtask
    task automatic t_end();
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0);
    endtask
    task automatic t_acc(input logic w, input logic [15:0] ad, input logic [15:0] dt);
        step(1'b0, 1'b0, 1'b0, 1'b1, w, ad, dt);
    endtask
    task automatic t_drain(input logic poke);
        for (int i = 0; i < 60; i++) begin
            if (ms == 0) break;
            // R10: access offered while streaming must be ignored
            step(1'b0, 1'b0, 1'b0, poke, 1'b0, 16'h0900, 16'h0BAD);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        rgn_begin = 0; rgn_kind = 0; rgn_end = 0; acc_valid = 0; acc_write = 0;
        acc_addr = 0; acc_data = 0; fl_ready = 0;
        sp_now = 16'h0100; sp_frame = 16'h0140;
        for (int l = 0; l < 6; l++) begin mo[l] = 1'b0; mk[l] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ev_ready == 1'b1, "R1 ev_ready after reset", int'(ev_ready), 1);
        chk(fl_valid == 1'b0, "R1 fl_valid after reset", int'(fl_valid), 0);

        // R5 frame filter and R3 order
        beats = 0;
        t_begin(1'b0);
        t_acc(1'b0, 16'h0200, 16'h0011);
        t_acc(1'b1, 16'h0120, 16'h0022);
        t_acc(1'b1, 16'h0300, 16'h0033);
        t_acc(1'b0, 16'h013F, 16'h0044);
        t_acc(1'b0, 16'h0140, 16'h0055);
        t_acc(1'b0, 16'h00FF, 16'h0066);
        t_end();
        t_drain(1'b0);
        chk(beats == 5, "R5 frame filter beat count", beats, 5);

        // R6 first read only
        beats = 0;
        t_begin(1'b1);
        t_acc(1'b1, 16'h0210, 16'h0001);
        t_acc(1'b0, 16'h0210, 16'h0001);
        t_acc(1'b0, 16'h0220, 16'h0002);
        t_acc(1'b0, 16'h0220, 16'h0002);
        t_acc(1'b1, 16'h0210, 16'h0003);
        t_end();
        t_drain(1'b0);
        chk(beats == 4, "R6 dedup beat count", beats, 4);

        // R4 nested recording, R10 ignored during stream
        beats = 0;
        t_begin(1'b1);
        t_acc(1'b0, 16'h0400, 16'h0A00);
        t_begin(1'b0);
        t_acc(1'b0, 16'h0500, 16'h0B00);
        t_acc(1'b1, 16'h0504, 16'h0C00);
        t_end();
        t_drain(1'b1);
        chk(beats == 3, "R4 inner flush beats", beats, 3);
        t_acc(1'b0, 16'h0600, 16'h0D00);
        t_end();
        t_drain(1'b0);
        chk(beats == 8, "R10 outer flush beats", beats, 8);

        // R2 end with nothing open
        beats = 0;
        t_end();
        t_drain(1'b0);
        chk(beats == 0, "R2 stray end", beats, 0);
        chk(ev_ready == 1'b1, "R2 ready after stray end", int'(ev_ready), 1);

        // R7 seventh level
        beats = 0;
        for (int i = 0; i < 7; i++) t_begin(i[0]);
        t_acc(1'b0, 16'h0700, 16'h0777);
        t_end();
        t_drain(1'b0);
        chk(beats == 0, "R7 deep end no stream", beats, 0);
        for (int i = 0; i < 6; i++) begin
            t_end();
            t_drain(1'b0);
        end
        chk(beats == 12, "R7 outer lines beats", beats, 12);

        // R8 overflow discard
        beats = 0;
        t_begin(1'b0);
        for (int i = 0; i < 9; i++) t_acc(1'b1, 16'h0800 + 16'(i), 16'(i));
        t_end();
        t_drain(1'b0);
        chk(beats == 0, "R8 overflow dropped", beats, 0);
        t_begin(1'b1);
        t_acc(1'b0, 16'h0880, 16'h0088);
        t_end();
        t_drain(1'b0);
        chk(beats == 2, "R8 depth restored", beats, 2);
        chk(md == 0, "R8 model depth", md, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule